// File: doc/BRIEF.md
# Carry-less Multiply and Bit-Count Unit

This block is a single-cycle integer execution slice for bit-manipulation work on 64-bit operands. In one cycle it either forms a carry-less (XOR-accumulated) product of two sources, or counts bits in the first source. It then registers the chosen result. A 4-bit operation code selects one of three windows of the 128-bit carry-less product, or one of six counting operations. Three of the counts look at the full 64 bits. The other three are word forms that see only the low 32 bits.

An issue stage presents `in_valid` with the code and both operands. Exactly one clock later, `out_valid` rises and `out_result` carries the answer. The unit has no internal states to sequence. Its only state is the result register and the valid flag: "idle" when `out_valid` is low, and "result presented" when it is high. An accepted input moves it to "result presented" for one cycle. A cycle with no valid input moves it back to "idle", and the register keeps its last value.

Top module: `clcu_unit`

## Requirements
- R1: Code 0000 returns bits 63:0 of the 128-bit carry-less product of `in_a` and `in_b`.
- R2: Code 0010 returns bits 127:64 of that product.
- R3: Code 0100 returns bits 126:63 of that product, with product bit 63 landing in result bit 0.
- R4: Code 1000 returns the count of leading zeros of `in_a`, and gives 64 for zero. Code 1001 counts leading zeros of `in_a[31:0]` and gives 32 when those bits are zero.
- R5: Code 1010 returns the count of trailing zeros of `in_a`, and gives 64 for zero. Code 1011 does the same over `in_a[31:0]` and gives 32 when those bits are zero.
- R6: Code 1100 returns the number of set bits in `in_a`. Code 1101 returns the number of set bits in `in_a[31:0]`.
- R7: Bit 3 of the code selects the count group, and within it bit 0 selects the word form. Word forms ignore `in_a[63:32]`, all counts ignore `in_b`, and every count is zero-extended to 64 bits.
- R8: `out_valid` equals `in_valid` from the previous clock, and the result of an accepted input appears on the following clock. Inputs may be accepted back to back.
- R9: When `in_valid` is low, `out_result` keeps its previous value.
- R10: Every other code (0001, 0011, 0101, 0110, 0111, 1110, 1111) returns zero.
- R11: While reset (`rst_n` low) is applied, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 64 | First source operand |
| in_b | input | 64 | Second source operand (product only) |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_result | output | 64 | Registered result |

## Verification
Some properties are checked on every clock:
- the one-cycle valid relationship;
- that the result holds on idle cycles;
- that count results never have bits set above bit 6;
- that undefined codes with bit 0 set produce zero;
- that a zero multiplier gives a zero low product;
- inside each counter, that a zero population coincides with a full-width leading- and trailing-zero count.

The exact numeric results of each product window and count can only be shown by the bench's scenarios. The same holds for the all-zero and top-bit boundaries, the word forms ignoring the upper half, and the remaining undefined codes. The bench compares these against its own reference model.

// File: rtl/clcu_pkg.sv
package clcu_pkg;
    localparam int XLEN = 64;
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_CLMUL  = 4'b0000,
        OP_CLMULH = 4'b0010,
        OP_CLMULR = 4'b0100,
        OP_CLZ    = 4'b1000,
        OP_CLZW   = 4'b1001,
        OP_CTZ    = 4'b1010,
        OP_CTZW   = 4'b1011,
        OP_CPOP   = 4'b1100,
        OP_CPOPW  = 4'b1101
    } clcu_op_e;

    // bit 3 selects the count group, bit 0 the word form inside it
    localparam int GROUP_BIT = 3;
    localparam int WORD_BIT  = 0;
endpackage

// File: rtl/clcu_clmul.sv
module clcu_clmul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    always_comb begin
        prod = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) prod = prod ^ ({{W{1'b0}}, a} << i);
        end
    end
endmodule

// File: rtl/clcu_bitcount.sv
module clcu_bitcount #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  v,
    output logic [CW-1:0] lz,
    output logic [CW-1:0] tz,
    output logic [CW-1:0] pop
);
    always_comb begin
        lz = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (v[i]) lz = CW'(W - 1 - i);
        end
    end

    always_comb begin
        tz = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i]) tz = CW'(i);
        end
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < W; i++) begin
            pop = pop + CW'(v[i]);
        end
    end

    // R4 R5 R6: zero population agrees with full-width zero counts
    always_comb begin
        if (!$isunknown(v)) begin
            zero_count_chk: assert (((pop == '0) == (lz == CW'(W))) && ((pop == '0) == (tz == CW'(W))))
                else $error("zero_count_chk: pop=%0d lz=%0d tz=%0d", pop, lz, tz);
        end
    end
endmodule

// File: rtl/clcu_unit.sv
module clcu_unit
    import clcu_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic          out_valid,
    output logic [DW-1:0] out_result
);
    localparam int HW  = DW / 2;
    localparam int CWF = $clog2(DW) + 1;
    localparam int CWH = $clog2(HW) + 1;

    logic [2*DW-1:0] prod;
    logic [CWF-1:0]  lz_f, tz_f, pop_f;
    logic [CWH-1:0]  lz_h, tz_h, pop_h;
    logic [DW-1:0]   next_result;

    clcu_clmul #(.W(DW)) u_clmul (
        .a    (in_a),
        .b    (in_b),
        .prod (prod)
    );

    clcu_bitcount #(.W(DW), .CW(CWF)) u_cnt_full (
        .v   (in_a),
        .lz  (lz_f),
        .tz  (tz_f),
        .pop (pop_f)
    );

    clcu_bitcount #(.W(HW), .CW(CWH)) u_cnt_word (
        .v   (in_a[HW-1:0]),
        .lz  (lz_h),
        .tz  (tz_h),
        .pop (pop_h)
    );

    always_comb begin
        next_result = '0;
        unique case (in_op)
            OP_CLMUL:  next_result = prod[DW-1:0];
            OP_CLMULH: next_result = prod[2*DW-1:DW];
            OP_CLMULR: next_result = prod[2*DW-2:DW-1];
            OP_CLZ:    next_result = {{(DW-CWF){1'b0}}, lz_f};
            OP_CLZW:   next_result = {{(DW-CWH){1'b0}}, lz_h};
            OP_CTZ:    next_result = {{(DW-CWF){1'b0}}, tz_f};
            OP_CTZW:   next_result = {{(DW-CWH){1'b0}}, tz_h};
            OP_CPOP:   next_result = {{(DW-CWF){1'b0}}, pop_f};
            OP_CPOPW:  next_result = {{(DW-CWH){1'b0}}, pop_h};
            default:   next_result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= next_result;
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    // R7
    count_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[GROUP_BIT]) |=> (out_result[DW-1:CWF] == '0));
    // R10
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[GROUP_BIT] && in_op[WORD_BIT]) |=> (out_result == '0));
    // R1
    clmul_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'b0000 && in_b == '0) |=> (out_result == '0));
endmodule

// File: tb/tb_clcu_unit.sv
`timescale 1ns/1ps
module tb_clcu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clcu_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{4'b0000, 64'h3, 64'h3, 64'h5},
        '{4'b0000, 64'hFF, 64'hFF, 64'h5555},
        '{4'b0010, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000},
        '{4'b0100, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
        '{4'b0010, 64'h3, 64'h3, 64'h0},
        '{4'b1000, 64'h0, 64'h0, 64'd64},
        '{4'b1000, 64'h1, 64'h0, 64'd63},
        '{4'b1000, 64'h8000_0000_0000_0000, 64'h0, 64'd0},
        '{4'b1001, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'd32},
        '{4'b1001, 64'h1, 64'h0, 64'd31},
        '{4'b1001, 64'hFFFF_FFFF_8000_0000, 64'h0, 64'd0},
        '{4'b1010, 64'h0, 64'h0, 64'd64},
        '{4'b1010, 64'h100, 64'h0, 64'd8},
        '{4'b1011, 64'hFFFF_0000_0000_0000, 64'h0, 64'd32},
        '{4'b1011, 64'h8000_0000, 64'h0, 64'd31},
        '{4'b1100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd64},
        '{4'b1100, 64'hF0F0, 64'h0, 64'd8},
        '{4'b1100, 64'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2},
        '{4'b1101, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd32},
        '{4'b1101, 64'hFFFF_FFFF_0000_0001, 64'h0, 64'd1},
        '{4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{4'b0110, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{4'b1110, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{4'b1111, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b0010: return "R2";
            4'b0100: return "R3";
            4'b1000, 4'b1001: return "R4";
            4'b1010, 4'b1011: return "R5";
            4'b1100, 4'b1101: return "R6";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [127:0] ref_prod(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] p = '0;
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                p[i+j] = p[i+j] ^ (a[i] & b[j]);
        return p;
    endfunction

    function automatic logic [63:0] ref_result(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [127:0] p;
        int w, n;
        p = ref_prod(a, b);
        w = op[0] ? 32 : 64;
        n = 0;
        case (op)
            4'b0000: return p[63:0];
            4'b0010: return p[127:64];
            4'b0100: return p[126:63];
            4'b1000, 4'b1001: begin
                while (n < w && !a[w-1-n]) n++;
                return 64'(n);
            end
            4'b1010, 4'b1011: begin
                while (n < w && !a[n]) n++;
                return 64'(n);
            end
            4'b1100, 4'b1101: begin
                for (int k = 0; k < w; k++) n += int'(a[k]);
                return 64'(n);
            end
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        logic [3:0] valid_ops [9] = '{4'h0, 4'h2, 4'h4, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD};

        // R11: reset state while reset is applied
        repeat (3) @(negedge clk);
        check("R11 out_valid", {63'b0, out_valid}, 64'h0);
        check("R11 out_result", out_result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, back to back (R8)
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].a, TBL[i].b);
            check("R8 out_valid", {63'b0, out_valid}, 64'h1);
            check(req_of(TBL[i].op), out_result, TBL[i].exp);
        end

        // R9: result held across idle cycles, and R8 valid drops
        held = out_result;
        in_valid = 1'b0; in_op = 4'b1100; in_a = 64'hDEAD_BEEF_0123_4567; in_b = 64'h1;
        repeat (3) @(negedge clk);
        check("R9 hold", out_result, held);
        check("R8 valid low", {63'b0, out_valid}, 64'h0);

        // R7: word forms ignore upper half; counts ignore in_b
        issue(4'b1101, 64'hABCD_EF01_0000_000F, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7 cpopw upper ignored", out_result, 64'd4);
        issue(4'b1001, 64'hFFFF_FFFF_0000_FFFF, 64'h1234);
        check("R7 clzw upper ignored", out_result, 64'd16);
        issue(4'b1011, 64'h0000_0001_0000_0000, 64'h0);
        check("R7 ctzw upper ignored", out_result, 64'd32);

        // random patterns against the reference model (R1 R2 R3 R4 R5 R6)
        for (int i = 0; i < 60; i++) begin
            logic [3:0] op;
            logic [63:0] a, b;
            op = valid_ops[$urandom_range(0, 8)];
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 7 == 3) a = a >> $urandom_range(0, 63);
            issue(op, a, b);
            check(req_of(op), out_result, ref_result(op, a, b));
        end
        in_valid = 1'b0;

        // R11: asynchronous reset clears a live result
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 reset clears result", out_result, 64'h0);
        check("R11 reset clears valid", {63'b0, out_valid}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule